// File: doc/BRIEF.md
# Virtual Timer Control Access Router

This block decides what happens when a 32-bit system-register instruction targets the virtual timer control register. The current privilege level (0 to 3), the register width used by levels 1 and 2, the host-mode and secure-state flags, a set of feature-present flags and the relevant enable and trap control bits feed a first-match priority decoder. The decoder names one outcome: undefined instruction, trap to level 1, trap to level 2 with a syndrome code, or an access steered to one of three physical timer control registers.

Reads and writes share the same decision, so the router has no direction input. The decision is registered once: the outputs in any cycle describe the inputs sampled at the previous rising clock edge. Carrying out the access and taking the exception belong to the neighbouring logic.

Top module: `vtimer_access_router`

## Requirements
- R1: While rst_ni is low, and until the first rising edge after it goes high, outcome, target_sel and syndrome are all zero.
- R2: One clock after any input set, outcome is one-hot with bit 0 = undefined, bit 1 = trap to level 1, bit 2 = trap to level 2, bit 3 = access.
- R3: When has_a32 is 0 the outcome is undefined at every privilege level, whatever the other inputs.
- R4: At level 0 with l1_w64=1, host_mode=0 and l1_u_vt_en=0, the result is a trap to level 2 with syndrome 0x03 when l2_on, l2_w64 and l2_tge are all 1; otherwise a trap to level 1 with syndrome 0x03.
- R5: At level 0 with l1_w64=0 and l1_u_vt_en=0: a trap to level 2 with syndrome 0x03 when l2_on, l2_w64 and l2_tge are 1; a trap to level 2 with syndrome 0x00 when l2_on and l2_tge are 1 and l2_w64 is 0; undefined otherwise.
- R6: At level 0 with host_mode=1, l2_w64=1 and l2_u_vt_en=0, the result is a trap to level 2 with syndrome 0x03.
- R7: At level 0 with host_mode=0, l2_on=1, l2_w64=1, has_ectr=1 and l2_vt_trap=1, the result is a trap to level 2 with syndrome 0x03.
- R8: A level-0 access that no trap rule catches selects target_sel 2 (secure host register) when host_mode, secure_st and has_sec_l2 are 1; target_sel 1 (non-secure host register) when host_mode is 1 and secure_st is 0; target_sel 0 (ordinary register) otherwise.
- R9: At level 1 the result is a trap to level 2 with syndrome 0x03 when l2_on, l2_w64, has_ectr and l2_vt_trap are all 1, and otherwise an access with target_sel 0; level 1 never traps to level 1.
- R10: At levels 2 and 3 the result is always an access with target_sel 0.
- R11: The level-0 rules are applied in the order R4, R5, R6, R7, R8 and the first that matches decides.
- R12: target_sel is 0 unless the outcome is access, and syndrome is 0 for undefined and access outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| has_a32 | input | 1 | 32-bit execution support is present |
| l1_w64 | input | 1 | Level 1 runs with 64-bit registers |
| l2_w64 | input | 1 | Level 2 runs with 64-bit registers |
| l2_on | input | 1 | Level 2 is enabled in the current state |
| host_mode | input | 1 | Level 0 runs under a host-mode level 2 |
| secure_st | input | 1 | Current security state is secure |
| has_sec_l2 | input | 1 | Secure level-2 support is present |
| has_ectr | input | 1 | Enhanced counter support is present |
| l1_u_vt_en | input | 1 | Level-1 control: level 0 may use the virtual timer |
| l2_u_vt_en | input | 1 | Level-2 control: level 0 may use the virtual timer in host mode |
| l2_vt_trap | input | 1 | Level-2 control: trap lower-level virtual timer accesses |
| l2_tge | input | 1 | Level-2 route-general-exceptions bit |
| outcome | output | 4 | One-hot result: undefined, trap L1, trap L2, access |
| target_sel | output | 2 | Selected register on access: 0 ordinary, 1 non-secure host, 2 secure host |
| syndrome | output | 8 | Trap syndrome code |

## Verification
The bench aims at the places where rules overlap: a level-0 access that meets both the level-1 enable rule and the enhanced-counter trap must go to level 1, and a design that checked the rules in the wrong order would send it to level 2. It separates the two level-2 trap flavours of the 32-bit level-1 case by syndrome, so a design that reused 0x03 for the 32-bit hypervisor trap, or that ignored l2_on, would report the wrong code or trap instead of faulting. It drives every trap bit at levels 2 and 3 and with 32-bit support absent, where a design leaking a lower-level rule upward, or checking support late, would trap or access instead. It also walks the three register targets in host mode, where swapping the secure and non-secure choices shows as a wrong target_sel.

// File: rtl/vtar_pkg.sv
package vtar_pkg;

    localparam int OUT_N   = 4;
    localparam int SEL_W   = 2;
    localparam int SYND_W  = 8;

    localparam int O_UNDEF = 0;
    localparam int O_TRAP1 = 1;
    localparam int O_TRAP2 = 2;
    localparam int O_ACC   = 3;

    localparam logic [SEL_W-1:0]  SEL_ORD  = 2'd0;
    localparam logic [SEL_W-1:0]  SEL_NSH  = 2'd1;
    localparam logic [SEL_W-1:0]  SEL_SECH = 2'd2;

    localparam logic [SYND_W-1:0] SYN_SYS  = 8'h03;
    localparam logic [SYND_W-1:0] SYN_HYP  = 8'h00;

    typedef struct packed {
        logic [OUT_N-1:0]  outc;
        logic [SEL_W-1:0]  sel;
        logic [SYND_W-1:0] synd;
    } decision_t;

    function automatic decision_t mk(input int kind,
                                     input logic [SEL_W-1:0] sel,
                                     input logic [SYND_W-1:0] synd);
        decision_t r;
        r.outc       = '0;
        r.outc[kind] = 1'b1;
        r.sel        = sel;
        r.synd       = synd;
        return r;
    endfunction

endpackage

// File: rtl/vtar_lvl0_rules.sv
module vtar_lvl0_rules
    import vtar_pkg::*;
(
    input  logic      l1_w64,
    input  logic      l2_w64,
    input  logic      l2_on,
    input  logic      host_mode,
    input  logic      secure_st,
    input  logic      has_sec_l2,
    input  logic      has_ectr,
    input  logic      l1_u_vt_en,
    input  logic      l2_u_vt_en,
    input  logic      l2_vt_trap,
    input  logic      l2_tge,
    output decision_t dec_o
);

    logic route_l2_64;
    logic route_l2_32;

    always_comb begin
        route_l2_64 = l2_on && l2_w64 && l2_tge;
        route_l2_32 = l2_on && !l2_w64 && l2_tge;

        if (l1_w64 && !host_mode && !l1_u_vt_en) begin
            dec_o = route_l2_64 ? mk(O_TRAP2, SEL_ORD, SYN_SYS)
                                : mk(O_TRAP1, SEL_ORD, SYN_SYS);
        end else if (!l1_w64 && !l1_u_vt_en) begin
            if (route_l2_64)
                dec_o = mk(O_TRAP2, SEL_ORD, SYN_SYS);
            else if (route_l2_32)
                dec_o = mk(O_TRAP2, SEL_ORD, SYN_HYP);
            else
                dec_o = mk(O_UNDEF, SEL_ORD, '0);
        end else if (host_mode && l2_w64 && !l2_u_vt_en) begin
            dec_o = mk(O_TRAP2, SEL_ORD, SYN_SYS);
        end else if (l2_on && l2_w64 && !host_mode && has_ectr && l2_vt_trap) begin
            dec_o = mk(O_TRAP2, SEL_ORD, SYN_SYS);
        end else if (host_mode && secure_st && has_sec_l2) begin
            dec_o = mk(O_ACC, SEL_SECH, '0);
        end else if (host_mode && !secure_st) begin
            dec_o = mk(O_ACC, SEL_NSH, '0);
        end else begin
            dec_o = mk(O_ACC, SEL_ORD, '0);
        end
    end

endmodule

// File: rtl/vtar_lvl1_rules.sv
module vtar_lvl1_rules
    import vtar_pkg::*;
(
    input  logic      l2_w64,
    input  logic      l2_on,
    input  logic      has_ectr,
    input  logic      l2_vt_trap,
    output decision_t dec_o
);

    always_comb begin
        if (l2_on && l2_w64 && has_ectr && l2_vt_trap)
            dec_o = mk(O_TRAP2, SEL_ORD, SYN_SYS);
        else
            dec_o = mk(O_ACC, SEL_ORD, '0);
    end

endmodule

// File: rtl/vtimer_access_router.sv
module vtimer_access_router
    import vtar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_ni,
    input  logic [1:0]        priv_lvl,
    input  logic              has_a32,
    input  logic              l1_w64,
    input  logic              l2_w64,
    input  logic              l2_on,
    input  logic              host_mode,
    input  logic              secure_st,
    input  logic              has_sec_l2,
    input  logic              has_ectr,
    input  logic              l1_u_vt_en,
    input  logic              l2_u_vt_en,
    input  logic              l2_vt_trap,
    input  logic              l2_tge,
    output logic [OUT_N-1:0]  outcome,
    output logic [SEL_W-1:0]  target_sel,
    output logic [SYND_W-1:0] syndrome
);

    decision_t lvl0_dec;
    decision_t lvl1_dec;
    decision_t dec_d;
    decision_t dec_q;

    vtar_lvl0_rules u_lvl0 (
        .l1_w64     (l1_w64),
        .l2_w64     (l2_w64),
        .l2_on      (l2_on),
        .host_mode  (host_mode),
        .secure_st  (secure_st),
        .has_sec_l2 (has_sec_l2),
        .has_ectr   (has_ectr),
        .l1_u_vt_en (l1_u_vt_en),
        .l2_u_vt_en (l2_u_vt_en),
        .l2_vt_trap (l2_vt_trap),
        .l2_tge     (l2_tge),
        .dec_o      (lvl0_dec)
    );

    vtar_lvl1_rules u_lvl1 (
        .l2_w64     (l2_w64),
        .l2_on      (l2_on),
        .has_ectr   (has_ectr),
        .l2_vt_trap (l2_vt_trap),
        .dec_o      (lvl1_dec)
    );

    // Missing 32-bit support outranks every level-specific rule.
    always_comb begin
        if (!has_a32)
            dec_d = mk(O_UNDEF, SEL_ORD, '0);
        else begin
            unique case (priv_lvl)
                2'd0:    dec_d = lvl0_dec;
                2'd1:    dec_d = lvl1_dec;
                default: dec_d = mk(O_ACC, SEL_ORD, '0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_ni)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign outcome    = dec_q.outc;
    assign target_sel = dec_q.sel;
    assign syndrome   = dec_q.synd;

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_ni)
        $past(rst_ni) |-> $onehot(outcome));

    a_r3_no_a32_undef: assert property (@(posedge clk) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(has_a32)) |-> outcome[O_UNDEF]);

    a_r9_lvl1_never_l1: assert property (@(posedge clk) disable iff (!rst_ni)
        ($past(rst_ni) && $past(priv_lvl) == 2'd1) |-> !outcome[O_TRAP1]);

    a_r10_high_lvl_ordinary: assert property (@(posedge clk) disable iff (!rst_ni)
        ($past(rst_ni) && $past(has_a32) && $past(priv_lvl) >= 2'd2)
            |-> (outcome[O_ACC] && target_sel == SEL_ORD));

    a_r12_sel_idle: assert property (@(posedge clk) disable iff (!rst_ni)
        !outcome[O_ACC] |-> target_sel == SEL_ORD);

    a_r12_synd_idle: assert property (@(posedge clk) disable iff (!rst_ni)
        (outcome[O_ACC] || outcome[O_UNDEF]) |-> syndrome == '0);

endmodule

// File: tb/test_vtimer_access_router.sv
module test_vtimer_access_router;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] priv_lvl;
    logic has_a32, l1_w64, l2_w64, l2_on, host_mode, secure_st, has_sec_l2;
    logic has_ectr, l1_u_vt_en, l2_u_vt_en, l2_vt_trap, l2_tge;
    logic [3:0] outcome;
    logic [1:0] target_sel;
    logic [7:0] syndrome;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [3:0] UND = 4'b0001, T1 = 4'b0010, T2 = 4'b0100, ACC = 4'b1000;

    always #5 clk = ~clk;

    vtimer_access_router i_vtimer_access_router (
        .clk(clk), .rst_ni(rst_ni), .priv_lvl(priv_lvl), .has_a32(has_a32),
        .l1_w64(l1_w64), .l2_w64(l2_w64), .l2_on(l2_on), .host_mode(host_mode),
        .secure_st(secure_st), .has_sec_l2(has_sec_l2), .has_ectr(has_ectr),
        .l1_u_vt_en(l1_u_vt_en), .l2_u_vt_en(l2_u_vt_en), .l2_vt_trap(l2_vt_trap),
        .l2_tge(l2_tge), .outcome(outcome), .target_sel(target_sel), .syndrome(syndrome)
    );

    // Baseline: 32-bit support present, all enables set, no trap bits.
    task automatic base(input logic [1:0] lvl);
        priv_lvl = lvl; has_a32 = 1; l1_w64 = 1; l2_w64 = 1; l2_on = 1;
        host_mode = 0; secure_st = 0; has_sec_l2 = 1; has_ectr = 1;
        l1_u_vt_en = 1; l2_u_vt_en = 1; l2_vt_trap = 0; l2_tge = 0;
    endtask

    // Inputs are set after a falling edge; the result is registered at the
    // next rising edge and sampled at the following falling edge.
    task automatic expect_dec(input string tag, input logic [3:0] eo,
                              input logic [1:0] es, input logic [7:0] ey);
        @(negedge clk);
        n_chk++;
        if (outcome !== eo || target_sel !== es || syndrome !== ey) begin
            n_bad++;
            $display("FAIL %s: got outcome=%b sel=%0d synd=%02h, expected outcome=%b sel=%0d synd=%02h",
                     tag, outcome, target_sel, syndrome, eo, es, ey);
        end
    endtask

    task automatic t_reset;
        base(2'd0);
        rst_ni = 0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (outcome !== 4'b0 || target_sel !== 2'b0 || syndrome !== 8'b0) begin
            n_bad++;
            $display("FAIL R1: got outcome=%b sel=%0d synd=%02h, expected all zero",
                     outcome, target_sel, syndrome);
        end
        rst_ni = 1;
        n_chk++;
        if (outcome !== 4'b0) begin
            n_bad++;
            $display("FAIL R1: got outcome=%b before first edge, expected 0000", outcome);
        end
    endtask

    task automatic t_no_a32;
        for (int l = 0; l < 4; l++) begin
            base(2'(l)); has_a32 = 0; l2_vt_trap = 1; l1_u_vt_en = 0;
            expect_dec("R3 no 32-bit support", UND, 2'd0, 8'h00);
        end
    endtask

    task automatic t_l1w64;
        base(2'd0); l1_u_vt_en = 0; l2_tge = 1;
        expect_dec("R4 route to L2", T2, 2'd0, 8'h03);
        base(2'd0); l1_u_vt_en = 0; l2_tge = 1; l2_on = 0;
        expect_dec("R4 L2 off -> L1", T1, 2'd0, 8'h03);
        base(2'd0); l1_u_vt_en = 0;
        expect_dec("R4 no tge -> L1", T1, 2'd0, 8'h03);
    endtask

    task automatic t_l1w32;
        base(2'd0); l1_w64 = 0; l1_u_vt_en = 0; l2_tge = 1;
        expect_dec("R5 L2 64-bit", T2, 2'd0, 8'h03);
        l2_w64 = 0;
        expect_dec("R5 L2 32-bit hyp trap", T2, 2'd0, 8'h00);
        l2_tge = 0;
        expect_dec("R5 no tge undefined", UND, 2'd0, 8'h00);
        l2_tge = 1; l2_on = 0;
        expect_dec("R5 L2 off undefined", UND, 2'd0, 8'h00);
    endtask

    task automatic t_host_en;
        base(2'd0); host_mode = 1; l2_u_vt_en = 0;
        expect_dec("R6 host enable clear", T2, 2'd0, 8'h03);
    endtask

    task automatic t_ectr;
        base(2'd0); l2_vt_trap = 1;
        expect_dec("R7 enhanced trap", T2, 2'd0, 8'h03);
        has_ectr = 0;
        expect_dec("R7 feature absent -> access", ACC, 2'd0, 8'h00);
        has_ectr = 1; host_mode = 1; secure_st = 0;
        expect_dec("R7 host mode skips trap", ACC, 2'd1, 8'h00);
    endtask

    task automatic t_targets;
        base(2'd0); host_mode = 1; secure_st = 1;
        expect_dec("R8 secure host", ACC, 2'd2, 8'h00);
        has_sec_l2 = 0;
        expect_dec("R8 secure no sec-L2 -> ordinary", ACC, 2'd0, 8'h00);
        secure_st = 0;
        expect_dec("R8 non-secure host", ACC, 2'd1, 8'h00);
        host_mode = 0;
        expect_dec("R8 ordinary", ACC, 2'd0, 8'h00);
    endtask

    task automatic t_priority;
        base(2'd0); l1_u_vt_en = 0; l2_vt_trap = 1;
        expect_dec("R11 R4 before R7", T1, 2'd0, 8'h03);
        base(2'd0); host_mode = 1; secure_st = 1; l2_u_vt_en = 0;
        expect_dec("R11 R6 before R8", T2, 2'd0, 8'h03);
    endtask

    task automatic t_lvl1;
        base(2'd1); l2_vt_trap = 1;
        expect_dec("R9 trap", T2, 2'd0, 8'h03);
        l2_w64 = 0;
        expect_dec("R9 L2 32-bit -> access", ACC, 2'd0, 8'h00);
        base(2'd1); l1_u_vt_en = 0; host_mode = 1; l2_tge = 1;
        expect_dec("R9 level-0 bits ignored", ACC, 2'd0, 8'h00);
    endtask

    task automatic t_high;
        for (int l = 2; l < 4; l++) begin
            base(2'(l)); l1_u_vt_en = 0; l2_u_vt_en = 0; l2_vt_trap = 1;
            l2_tge = 1; host_mode = 1; secure_st = 1;
            expect_dec("R10 high level ordinary", ACC, 2'd0, 8'h00);
        end
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        t_no_a32();
        t_l1w64();
        t_l1w32();
        t_host_en();
        t_ectr();
        t_targets();
        t_priority();
        t_lvl1();
        t_high();
        // R2 and R12 are covered by the exact outcome/sel/syndrome compares above.
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule